// File: doc/BRIEF.md
# Reset Line Controller

This block drives a bank of active-low reset outputs, one per peripheral clock domain, from a small set of memory-mapped control registers, and reports the state each domain has actually reached through read-only status registers. Software sets a bit to hold a line in reset and clears it to release the line. It then polls the matching status bit until the requested state shows. A pulse reset is a hold followed by a release, and software confirms each step separately.

Holding a line in reset reaches the target domain at once, with no target clock edge needed. A release reaches the target only through a synchronizer clocked by that domain's own clock, and only on cycles where the domain's clock enable is high. The domain's view of its reset is carried back into the bus clock before it appears in status. A release toward a gated domain therefore never shows in status, and software has to detect that with its own timeout. Most status bits read 1 for a released line. A parameter mask marks the lines whose status reads 1 while held, so with every line held the status space reads back exactly that mask.

Top module: `rst_line_ctrl`

## Requirements
- R1: The register port is 64 bits wide and takes one request per cycle (`req_ready` is always 1). Address bits [2:0] are ignored. Byte address 0x00 holds lines 0..63 and 0x08 holds lines 64..127, and status for the same lines sits at 0x10 and 0x18. In each 64-bit word, bits [31:0] are the 32-bit register at the lower address (line 32m+n is bit n of the register at 4m) and bits [63:32] are the one 4 bytes above. A read accepted in one cycle returns `rsp_valid`=1 with the data in the next cycle, and `rsp_valid` is 0 in every other cycle.
- R2: A write to a control word sets the hold bit of each covered line to the written bit, where 1 holds the line in reset and 0 releases it. Control words read back as written.
- R3: Byte enable b applies only to write-data bits [8b+7:8b]. Lanes whose enable is 0 keep their lines unchanged.
- R4: After `rst_n` every implemented line's hold bit reads 1 and its `tgt_rst_n` is 0.
- R5: A status bit reads the inverted reset state (1 = released), except for lines whose bit is set in `STATUS_POL`, which read 1 while held. With every line held, the status space equals `STATUS_POL`.
- R6: Setting a hold bit drives `tgt_rst_n` low without waiting for a target clock edge, even when that line's clock enable is 0.
- R7: A release reaches `tgt_rst_n` only after two enabled target clock edges, and status shows it only after two further bus clock edges. A status read issued in the cycle after the release write still shows the held state.
- R8: While a line's `tgt_clk_en` is 0, its `tgt_rst_n` does not rise and its status keeps its value. Once the enable returns to 1, the pending release completes.
- R9: Writes to status addresses change no hold bit.
- R10: Reads at byte addresses 0x20 and above (pair index 4 or more) return zero.
- R11: Lines at or above `IMPL_LINES` have hold bits fixed at 0 whatever is written, keep `tgt_rst_n` at 1, and read their `STATUS_POL` bit in status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 8 | Byte enables for writes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| tgt_clk | input | NUM_LINES | Target clock per line |
| tgt_clk_en | input | NUM_LINES | Target clock enable per line (0 models gating) |
| tgt_rst_n | output | NUM_LINES | Active-low reset into each target domain |

## Verification
The bench builds the block with 128 lines, of which only 100 are implemented. Lines 100..127 therefore lie in the upper half of the last word, next to four live lines, and a single write shows at once that live bits follow the data while dead bits stay zero. Its polarity mask has bits in all four 32-bit words, and one of them lies on an unimplemented line, so non-inverted status is seen both on live lines and on fixed ones. Every target domain runs from one 26-unit clock unrelated to the 20-unit bus clock, which leaves room for the cycle-after-release read that must still show the held state, and for holding a release open indefinitely by dropping one line's enable.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

   localparam int unsigned BUS_W   = 64;
   localparam int unsigned LANE_W  = 8;
   localparam int unsigned N_LANES = BUS_W / LANE_W;

   typedef enum logic [1:0] {
      SPACE_HOLD   = 2'd0,
      SPACE_STATUS = 2'd1,
      SPACE_NONE   = 2'd2
   } space_e;

endpackage

// File: rtl/rlc_regfile.sv
module rlc_regfile
   import rlc_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 128,
   parameter int unsigned IMPL_LINES = 128,
   parameter int unsigned ADDR_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [N_LANES-1:0]   req_be,
   input  logic [BUS_W-1:0]     req_wdata,
   output logic                 rsp_valid,
   output logic [BUS_W-1:0]     rsp_rdata,
   input  logic [NUM_LINES-1:0] status_i,
   output logic [NUM_LINES-1:0] hold_o
);

   localparam int unsigned N_PAIRS = NUM_LINES / BUS_W;
   localparam int unsigned PAIR_W  = ADDR_W - 3;

   function automatic logic [NUM_LINES-1:0] live_mask();
      logic [NUM_LINES-1:0] m;
      for (int i = 0; i < NUM_LINES; i++) m[i] = (i < IMPL_LINES);
      return m;
   endfunction

   localparam logic [NUM_LINES-1:0] LIVE = live_mask();

   if (ADDR_W < 4 || (2 * N_PAIRS) >= (1 << PAIR_W)) begin : g_bad_addr
      $error("rlc_regfile: ADDR_W too small for the register space");
   end

   logic [PAIR_W-1:0]    pair;
   logic [PAIR_W-1:0]    pair_sel;
   space_e               space;
   logic [NUM_LINES-1:0] hold_q;
   logic [NUM_LINES-1:0] hold_d;
   logic [BUS_W-1:0]     rd_word;
   logic                 rd_take;
   logic                 unused_addr_low;

   assign unused_addr_low = ^req_addr[2:0];
   assign pair            = req_addr[ADDR_W-1:3];
   assign rd_take         = req_valid && !req_write;

   always_comb begin
      if (pair < PAIR_W'(N_PAIRS)) begin
         space    = SPACE_HOLD;
         pair_sel = pair;
      end else if (pair < PAIR_W'(2 * N_PAIRS)) begin
         space    = SPACE_STATUS;
         pair_sel = pair - PAIR_W'(N_PAIRS);
      end else begin
         space    = SPACE_NONE;
         pair_sel = '0;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int p = 0; p < N_PAIRS; p++) begin
         if (pair_sel == PAIR_W'(p)) begin
            if (space == SPACE_HOLD)   rd_word = hold_q[p*BUS_W +: BUS_W];
            if (space == SPACE_STATUS) rd_word = status_i[p*BUS_W +: BUS_W];
         end
      end
   end

   always_comb begin
      hold_d = hold_q;
      if (req_valid && req_write && space == SPACE_HOLD) begin
         for (int p = 0; p < N_PAIRS; p++) begin
            for (int b = 0; b < N_LANES; b++) begin
               if (pair_sel == PAIR_W'(p) && req_be[b])
                  hold_d[p*BUS_W + b*LANE_W +: LANE_W] = req_wdata[b*LANE_W +: LANE_W];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= LIVE;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         hold_q    <= hold_d & LIVE;
         rsp_valid <= rd_take;
         if (rd_take) rsp_rdata <= rd_word;
      end
   end

   assign hold_o = hold_q;

   // R1: a read gets exactly one response, one cycle later
   p_rsp_follows_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |=> rsp_valid);
   p_rsp_only_for_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_take |=> !rsp_valid);
   // R9: writes outside the control space leave hold bits alone
   p_status_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && space != SPACE_HOLD) |=> $stable(hold_q));
   // R3: a write with no lanes enabled changes nothing
   p_no_lane_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_be == '0) |=> $stable(hold_q));

endmodule

// File: rtl/rlc_line_sync.sv
module rlc_line_sync #(
   parameter int unsigned TGT_STAGES = 2,
   parameter int unsigned ACK_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_req,
   input  logic tgt_clk,
   input  logic tgt_clk_en,
   output logic tgt_rst_n,
   output logic held_seen
);

   if (TGT_STAGES < 2 || ACK_STAGES < 2) begin : g_bad_stages
      $error("rlc_line_sync: synchronizers need at least two stages");
   end

   logic [TGT_STAGES-1:0] tchain;
   logic [ACK_STAGES-1:0] achain;

   // hold clears the chain at once; release walks in on enabled target edges
   always_ff @(posedge tgt_clk or posedge hold_req) begin
      if (hold_req)        tchain <= '0;
      else if (tgt_clk_en) tchain <= {tchain[TGT_STAGES-2:0], 1'b1};
   end

   assign tgt_rst_n = tchain[TGT_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) achain <= '0;
      else        achain <= {achain[ACK_STAGES-2:0], tgt_rst_n};
   end

   assign held_seen = ~achain[ACK_STAGES-1];

   // R6: a hold seen on a bus edge has already reached the target
   p_hold_reaches_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_req |-> !tgt_rst_n);
   // R7: the acknowledge path only sees a release the target really took
   p_ack_after_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
      achain[0] |-> !$past(hold_req));
   // R8: no release on a gated target edge
   p_gated_no_release_r8: assert property (@(posedge tgt_clk) disable iff (!rst_n)
      !tgt_clk_en |=> !$rose(tgt_rst_n));

endmodule

// File: rtl/rst_line_ctrl.sv
module rst_line_ctrl
   import rlc_pkg::*;
#(
   parameter int unsigned          NUM_LINES  = 128,
   parameter int unsigned          IMPL_LINES = 128,
   parameter int unsigned          ADDR_W     = 8,
   parameter int unsigned          TGT_STAGES = 2,
   parameter int unsigned          ACK_STAGES = 2,
   parameter logic [NUM_LINES-1:0] STATUS_POL = NUM_LINES'(128'h0000_0000_0000_0001_0000_0018_0000_0007)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [7:0]           req_be,
   input  logic [63:0]          req_wdata,
   output logic                 rsp_valid,
   output logic [63:0]          rsp_rdata,
   input  logic [NUM_LINES-1:0] tgt_clk,
   input  logic [NUM_LINES-1:0] tgt_clk_en,
   output logic [NUM_LINES-1:0] tgt_rst_n
);

   if (NUM_LINES == 0 || NUM_LINES % BUS_W != 0) begin : g_bad_lines
      $error("rst_line_ctrl: NUM_LINES must be a nonzero multiple of 64");
   end
   if (IMPL_LINES > NUM_LINES) begin : g_bad_impl
      $error("rst_line_ctrl: IMPL_LINES exceeds NUM_LINES");
   end

   logic [NUM_LINES-1:0] hold_vec;
   logic [NUM_LINES-1:0] status_vec;

   assign req_ready = 1'b1;

   rlc_regfile #(
      .NUM_LINES  (NUM_LINES),
      .IMPL_LINES (IMPL_LINES),
      .ADDR_W     (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .status_i  (status_vec),
      .hold_o    (hold_vec)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (i < IMPL_LINES) begin : g_live
         logic held;
         rlc_line_sync #(
            .TGT_STAGES (TGT_STAGES),
            .ACK_STAGES (ACK_STAGES)
         ) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold_req   (hold_vec[i]),
            .tgt_clk    (tgt_clk[i]),
            .tgt_clk_en (tgt_clk_en[i]),
            .tgt_rst_n  (tgt_rst_n[i]),
            .held_seen  (held)
         );
         if (STATUS_POL[i]) begin : g_plain
            assign status_vec[i] = held;
         end else begin : g_inv
            assign status_vec[i] = ~held;
         end
      end else begin : g_dead
         logic unused_pins;
         assign unused_pins   = tgt_clk[i] ^ tgt_clk_en[i] ^ hold_vec[i];
         assign tgt_rst_n[i]  = 1'b1;
         assign status_vec[i] = STATUS_POL[i];
      end
   end

endmodule

// File: tb/test_rst_line_ctrl.sv
module test_rst_line_ctrl;

   localparam int unsigned NL   = 128;
   localparam int unsigned IMPL = 100;
   localparam int unsigned AW   = 8;
   localparam logic [NL-1:0] POL = 128'h0100_0000_0000_0001_0000_0018_8000_0007;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [7:0]  be;
      logic [63:0] data;
      logic [63:0] exp;
      logic [7:0]  rq;
   } vec_t;

   // rq holds the requirement number: R1 R2 R3 R4 R5 R9 R10 R11
   localparam vec_t TAB [0:24] = '{
      '{1'b0, 8'h00, 8'h00, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd4},  // R4
      '{1'b0, 8'h08, 8'h00, 64'h0, 64'h0000_000F_FFFF_FFFF, 8'd11}, // R11
      '{1'b0, 8'h10, 8'h00, 64'h0, 64'h0000_0018_8000_0007, 8'd5},  // R5
      '{1'b0, 8'h18, 8'h00, 64'h0, 64'h0100_0000_0000_0001, 8'd11}, // R11
      '{1'b1, 8'h00, 8'hFF, 64'h0, 64'h0, 8'd2},
      '{1'b0, 8'h00, 8'h00, 64'h0, 64'h0, 8'd2},                    // R2
      '{1'b0, 8'h10, 8'h00, 64'h0, 64'hFFFF_FFE7_7FFF_FFF8, 8'd5},  // R5
      '{1'b1, 8'h08, 8'h0F, 64'h0, 64'h0, 8'd3},
      '{1'b0, 8'h08, 8'h00, 64'h0, 64'h0000_000F_0000_0000, 8'd3},  // R3
      '{1'b0, 8'h18, 8'h00, 64'h0, 64'h0100_0000_FFFF_FFFE, 8'd5},  // R5
      '{1'b1, 8'h08, 8'hF0, 64'h0, 64'h0, 8'd11},
      '{1'b0, 8'h18, 8'h00, 64'h0, 64'h0100_000F_FFFF_FFFE, 8'd11}, // R11
      '{1'b1, 8'h08, 8'hF0, 64'hFFFF_FFFF_0000_0000, 64'h0, 8'd11},
      '{1'b0, 8'h08, 8'h00, 64'h0, 64'h0000_000F_0000_0000, 8'd11}, // R11
      '{1'b1, 8'h00, 8'h02, 64'h0000_0000_0000_AB00, 64'h0, 8'd3},
      '{1'b0, 8'h00, 8'h00, 64'h0, 64'h0000_0000_0000_AB00, 8'd3},  // R3
      '{1'b0, 8'h10, 8'h00, 64'h0, 64'hFFFF_FFE7_7FFF_54F8, 8'd2},  // R2
      '{1'b1, 8'h10, 8'hFF, 64'h0, 64'h0, 8'd9},
      '{1'b0, 8'h10, 8'h00, 64'h0, 64'hFFFF_FFE7_7FFF_54F8, 8'd9},  // R9
      '{1'b0, 8'h00, 8'h00, 64'h0, 64'h0000_0000_0000_AB00, 8'd9},  // R9
      '{1'b0, 8'h20, 8'h00, 64'h0, 64'h0, 8'd10},                   // R10
      '{1'b0, 8'h38, 8'h00, 64'h0, 64'h0, 8'd10},                   // R10
      '{1'b1, 8'h04, 8'hF0, 64'h0000_0001_0000_0000, 64'h0, 8'd1},
      '{1'b0, 8'h04, 8'h00, 64'h0, 64'h0000_0001_0000_AB00, 8'd1},  // R1
      '{1'b0, 8'h10, 8'h00, 64'h0, 64'hFFFF_FFE6_7FFF_54F8, 8'd1}   // R1
   };

   logic          clk = 1'b0;
   logic          tclk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_be = '0;
   logic [63:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [63:0]   rsp_rdata;
   logic [NL-1:0] tgt_clk;
   logic [NL-1:0] tgt_clk_en = '1;
   logic [NL-1:0] tgt_rst_n;

   int unsigned n_checks = 0;
   int unsigned n_fails  = 0;
   logic        done = 1'b0;

   always #10 clk = ~clk;
   always #13 tclk = ~tclk;
   assign tgt_clk = {NL{tclk}};

   rst_line_ctrl #(
      .NUM_LINES  (NL),
      .IMPL_LINES (IMPL),
      .ADDR_W     (AW),
      .STATUS_POL (POL)
   ) i_rst_line_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_be     (req_be),
      .req_wdata  (req_wdata),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .tgt_clk    (tgt_clk),
      .tgt_clk_en (tgt_clk_en),
      .tgt_rst_n  (tgt_rst_n)
   );

   task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string rq);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic bus_write(input logic [7:0] a, input logic [7:0] be, input logic [63:0] d);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = a;
      req_be    = be;
      req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [63:0] d, output logic ok);
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      d  = rsp_rdata;
      ok = rsp_valid;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_chk(input logic [7:0] a, input logic [63:0] exp, input string rq);
      logic [63:0] d;
      logic        ok;
      bus_read(a, d, ok);
      chk({127'h0, ok}, 128'h1, "R1 rsp_valid");
      chk({64'h0, d}, {64'h0, exp}, rq);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R4 / R11: line outputs after reset
      chk({28'h0, tgt_rst_n[99:0]}, 128'h0, "R4 tgt_rst_n live");
      chk({100'h0, tgt_rst_n[127:100]}, {100'h0, 28'hFFF_FFFF}, "R11 tgt_rst_n dead");
      chk({127'h0, req_ready}, 128'h1, "R1 req_ready");

      for (int k = 0; k < 25; k++) begin
         if (TAB[k].wr) begin
            bus_write(TAB[k].addr, TAB[k].be, TAB[k].data);
            idle(20);
         end else begin
            read_chk(TAB[k].addr, TAB[k].exp, $sformatf("R%0d vector %0d", TAB[k].rq, k));
         end
      end

      // R6 / R8: hold line 1 (non-inverted) with its clock gated
      tgt_clk_en[1] = 1'b0;
      bus_write(8'h00, 8'h01, 64'h0000_0000_0000_0002);
      chk({127'h0, tgt_rst_n[1]}, 128'h0, "R6 hold without target clock");
      idle(20);
      read_chk(8'h10, 64'hFFFF_FFE6_7FFF_54FA, "R5 held plain line reads 1");

      // R8: release while gated is never taken
      bus_write(8'h00, 8'h01, 64'h0);
      idle(100);
      read_chk(8'h10, 64'hFFFF_FFE6_7FFF_54FA, "R8 gated status holds");
      chk({127'h0, tgt_rst_n[1]}, 128'h0, "R8 gated line stays held");
      tgt_clk_en[1] = 1'b1;
      idle(20);
      read_chk(8'h10, 64'hFFFF_FFE6_7FFF_54F8, "R8 release after enable");
      chk({127'h0, tgt_rst_n[1]}, 128'h1, "R8 line released after enable");

      // R7: release line 8, read status in the very next cycle
      bus_write(8'h00, 8'h02, 64'h0000_0000_0000_AA00);
      read_chk(8'h10, 64'hFFFF_FFE6_7FFF_54F8, "R7 status not yet released");
      idle(20);
      read_chk(8'h10, 64'hFFFF_FFE6_7FFF_55F8, "R7 status released later");
      chk({127'h0, tgt_rst_n[8]}, 128'h1, "R7 target line released");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule